// File: doc/BRIEF.md
# Collapsing Oldest-First Issue Queue

This block holds renamed instructions between the rename stage and the functional units. Each entry carries two source physical tags with a ready flag for each, a destination tag, a functional-unit class and a window sequence number. Entries are kept packed at the low end of the array in program order, so entry 0 is always the oldest. Result tags broadcast on the wakeup ports set the ready flag of every matching source, including sources being written in that same cycle.

Each cycle the selector walks the queue from the oldest entry and grants up to `ISSUE_W` entries whose sources are both ready and whose class has a free unit. Granted entries leave the queue at the next edge. At that edge the survivors close up the gaps and the new instructions are appended after them, so issue slots never stay occupied by dead entries. A squash port removes every entry younger than a given sequence number, using modular comparison, so the window may wrap.

Top module: `iq_collapse_top`

## Requirements
- R1: After reset the queue is empty: `iss_valid` is all zero and `ins_stall` is low while `ins_valid` is zero.
- R2: An entry is eligible when both ready flags are set. Up to `ISSUE_W` eligible entries are granted per cycle, oldest first. Slots fill from slot 0 upward, so slot 0 holds the oldest granted entry and `iss_valid` is packed from bit 0.
- R3: A wakeup (`wk_valid[j]` high, `wk_tag[j]` equal to a stored source tag) sets that ready flag at the clock edge. Selection in the wakeup cycle uses the flags as stored before the edge, so the woken entry can issue in the next cycle at the earliest.
- R4: A wakeup in the same cycle as an insertion sets the ready flag of a matching source of the inserted instruction.
- R5: A granted entry is removed at the edge that ends its issue cycle. Entries that remain keep their relative age order and close up towards entry 0.
- R6: A squash (`sq_valid` high) kills every entry whose sequence number is younger than `sq_seq`. Younger means that (seq - sq_seq) mod 2^7 is nonzero and below 64. A killed entry is not granted in the squash cycle and is gone afterwards. The entry equal to `sq_seq` and older entries are kept.
- R7: Requested lanes are the set bits of `ins_valid`, contiguous from bit 0. On acceptance they are appended after the surviving entries, and lane 0 counts as older than lane 1 and so on.
- R8: `ins_stall` is high when `sq_valid` is high, or when the free slots (`DEPTH` minus the occupancy at the start of the cycle) are fewer than the number of set bits in `ins_valid`. When `ins_stall` is high nothing is inserted.
- R9: An entry is granted only if `fu_avail[cls]` is high, where `cls` is the entry's 2-bit class. Entries of unavailable classes are skipped and younger eligible entries are granted instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | INS_W | Insertion request per lane |
| ins_src1 | input | INS_W x 7 | First source physical tag per lane |
| ins_src1_rdy | input | INS_W | First source already ready |
| ins_src2 | input | INS_W x 7 | Second source physical tag per lane |
| ins_src2_rdy | input | INS_W | Second source already ready |
| ins_dst | input | INS_W x 7 | Destination physical tag per lane |
| ins_cls | input | INS_W x 2 | Functional-unit class per lane |
| ins_seq | input | INS_W x 7 | Window sequence number per lane |
| ins_stall | output | 1 | Insertion refused this cycle |
| wk_valid | input | WK_W | Wakeup broadcast valid per port |
| wk_tag | input | WK_W x 7 | Broadcast result tag per port |
| fu_avail | input | 4 | Free unit per class |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | 7 | Sequence number of the faulting instruction |
| iss_valid | output | ISSUE_W | Issue slot carries a granted entry |
| iss_dst | output | ISSUE_W x 7 | Destination tag of the granted entry |
| iss_cls | output | ISSUE_W x 2 | Class of the granted entry |
| iss_seq | output | ISSUE_W x 7 | Sequence number of the granted entry |

## Verification
The bench uses the defaults: 20 entries, 4 issue slots, 4 insertion lanes and 4 wakeup ports. With these values the queue can be filled exactly to its limit in five insertions, so both the partial refusal (two free slots against four requests) and the full refusal can be reached. It also holds more ready entries than there are slots, which shows a second issue wave. The 7-bit sequence numbers let a squash straddle the wrap from 127 to 0 with only four instructions.

// File: rtl/iq_pkg.sv
package iq_pkg;

    localparam int IQ_TAG_W = 7;
    localparam int IQ_SEQ_W = 7;
    localparam int IQ_CLS_W = 2;
    localparam int IQ_NCLS  = 1 << IQ_CLS_W;

    typedef struct packed {
        logic                vld;
        logic [IQ_TAG_W-1:0] s1;
        logic                r1;
        logic [IQ_TAG_W-1:0] s2;
        logic                r2;
        logic [IQ_TAG_W-1:0] dst;
        logic [IQ_CLS_W-1:0] cls;
        logic [IQ_SEQ_W-1:0] seq;
    } iq_ent_t;

    // Modular age test: a is younger than b inside a half-range window.
    function automatic logic iq_younger(logic [IQ_SEQ_W-1:0] a,
                                        logic [IQ_SEQ_W-1:0] b);
        logic [IQ_SEQ_W-1:0] d;
        d = a - b;
        return (d != '0) && !d[IQ_SEQ_W-1];
    endfunction

endpackage

// File: rtl/iq_wakeup.sv
module iq_wakeup
    import iq_pkg::*;
#(
    parameter int N    = 20,
    parameter int WK_W = 4
) (
    input  iq_ent_t [N-1:0]                   ents_i,
    input  logic    [WK_W-1:0]                wk_valid,
    input  logic    [WK_W-1:0][IQ_TAG_W-1:0]  wk_tag,
    output iq_ent_t [N-1:0]                   ents_o
);

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic    hit1;
        logic    hit2;
        iq_ent_t upd;

        always_comb begin
            hit1 = 1'b0;
            hit2 = 1'b0;
            for (int j = 0; j < WK_W; j++) begin
                if (wk_valid[j] && (wk_tag[j] == ents_i[g].s1)) hit1 = 1'b1;
                if (wk_valid[j] && (wk_tag[j] == ents_i[g].s2)) hit2 = 1'b1;
            end
            upd    = ents_i[g];
            upd.r1 = ents_i[g].r1 | hit1;
            upd.r2 = ents_i[g].r2 | hit2;
        end

        assign ents_o[g] = upd;
    end

endmodule

// File: rtl/iq_select.sv
module iq_select
    import iq_pkg::*;
#(
    parameter int DEPTH   = 20,
    parameter int ISSUE_W = 4,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int SLOT_W = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1,
    localparam int SCNT_W = $clog2(ISSUE_W + 1)
) (
    input  iq_ent_t [DEPTH-1:0]              ents,
    input  logic    [DEPTH-1:0]              kill,
    input  logic    [IQ_NCLS-1:0]            fu_avail,
    output logic    [DEPTH-1:0]              grant,
    output logic    [ISSUE_W-1:0]            slot_vld,
    output logic    [ISSUE_W-1:0][IDX_W-1:0] slot_idx
);

    logic [DEPTH-1:0] elig;

    for (genvar g = 0; g < DEPTH; g++) begin : g_elig
        assign elig[g] = ents[g].vld & ents[g].r1 & ents[g].r2
                       & fu_avail[ents[g].cls] & ~kill[g];
    end

    // Walk from entry 0 (oldest); each eligible entry takes the next slot.
    logic [SCNT_W-1:0] used;

    always_comb begin
        grant    = '0;
        slot_vld = '0;
        slot_idx = '0;
        used     = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (elig[i] && (used < SCNT_W'(ISSUE_W))) begin
                grant[i]                     = 1'b1;
                slot_vld[used[SLOT_W-1:0]]   = 1'b1;
                slot_idx[used[SLOT_W-1:0]]   = IDX_W'(i);
                used                         = used + 1'b1;
            end
        end
    end

endmodule

// File: rtl/iq_compact.sv
module iq_compact
    import iq_pkg::*;
#(
    parameter int DEPTH  = 20,
    parameter int INS_W  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  iq_ent_t [DEPTH-1:0] ents,
    input  logic    [DEPTH-1:0] keep,
    input  iq_ent_t [INS_W-1:0] new_ents,
    input  logic    [INS_W-1:0] new_vld,
    input  logic                ins_en,
    output iq_ent_t [DEPTH-1:0] nxt,
    output logic    [CNT_W-1:0] nxt_cnt
);

    logic [CNT_W-1:0] pos;

    always_comb begin
        nxt = '0;
        pos = '0;
        // Survivors close up towards entry 0, preserving order.
        for (int i = 0; i < DEPTH; i++) begin
            if (keep[i]) begin
                nxt[pos]     = ents[i];
                nxt[pos].vld = 1'b1;
                pos          = pos + 1'b1;
            end
        end
        // New lanes follow the survivors, lane 0 oldest.
        for (int k = 0; k < INS_W; k++) begin
            if (ins_en && new_vld[k] && (pos < CNT_W'(DEPTH))) begin
                nxt[pos]     = new_ents[k];
                nxt[pos].vld = 1'b1;
                pos          = pos + 1'b1;
            end
        end
        nxt_cnt = pos;
    end

endmodule

// File: rtl/iq_collapse_top.sv
module iq_collapse_top
    import iq_pkg::*;
#(
    parameter int DEPTH   = 20,
    parameter int ISSUE_W = 4,
    parameter int INS_W   = 4,
    parameter int WK_W    = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [INS_W-1:0]                  ins_valid,
    input  logic [INS_W-1:0][IQ_TAG_W-1:0]    ins_src1,
    input  logic [INS_W-1:0]                  ins_src1_rdy,
    input  logic [INS_W-1:0][IQ_TAG_W-1:0]    ins_src2,
    input  logic [INS_W-1:0]                  ins_src2_rdy,
    input  logic [INS_W-1:0][IQ_TAG_W-1:0]    ins_dst,
    input  logic [INS_W-1:0][IQ_CLS_W-1:0]    ins_cls,
    input  logic [INS_W-1:0][IQ_SEQ_W-1:0]    ins_seq,
    output logic                              ins_stall,
    input  logic [WK_W-1:0]                   wk_valid,
    input  logic [WK_W-1:0][IQ_TAG_W-1:0]     wk_tag,
    input  logic [IQ_NCLS-1:0]                fu_avail,
    input  logic                              sq_valid,
    input  logic [IQ_SEQ_W-1:0]               sq_seq,
    output logic [ISSUE_W-1:0]                iss_valid,
    output logic [ISSUE_W-1:0][IQ_TAG_W-1:0]  iss_dst,
    output logic [ISSUE_W-1:0][IQ_CLS_W-1:0]  iss_cls,
    output logic [ISSUE_W-1:0][IQ_SEQ_W-1:0]  iss_seq
);

    iq_ent_t [DEPTH-1:0] q_ents;
    iq_ent_t [DEPTH-1:0] q_woke;
    iq_ent_t [DEPTH-1:0] n_ents;
    logic    [CNT_W-1:0] q_cnt;
    logic    [CNT_W-1:0] n_cnt;

    iq_ent_t [INS_W-1:0] in_raw;
    iq_ent_t [INS_W-1:0] in_woke;

    logic [DEPTH-1:0]              kill;
    logic [DEPTH-1:0]              grant;
    logic [DEPTH-1:0]              keep;
    logic [ISSUE_W-1:0]            slot_vld;
    logic [ISSUE_W-1:0][IDX_W-1:0] slot_idx;
    logic                          ins_en;

    // Incoming lanes as entries.
    for (genvar k = 0; k < INS_W; k++) begin : g_lane
        assign in_raw[k] = '{vld: ins_valid[k],
                             s1:  ins_src1[k], r1: ins_src1_rdy[k],
                             s2:  ins_src2[k], r2: ins_src2_rdy[k],
                             dst: ins_dst[k],  cls: ins_cls[k],
                             seq: ins_seq[k]};
    end

    // Squash kill mask: younger than the faulting sequence number.
    for (genvar g = 0; g < DEPTH; g++) begin : g_kill
        assign kill[g] = sq_valid & q_ents[g].vld & iq_younger(q_ents[g].seq, sq_seq);
        assign keep[g] = q_ents[g].vld & ~grant[g] & ~kill[g];
    end

    // Backpressure against occupancy at the start of the cycle.
    always_comb begin
        ins_stall = sq_valid ||
                    ((int'(DEPTH) - int'(q_cnt)) < $countones(ins_valid));
        ins_en    = (ins_valid != '0) && !ins_stall;
    end

    iq_wakeup #(.N(DEPTH), .WK_W(WK_W)) u_wk_q (
        .ents_i   (q_ents),
        .wk_valid (wk_valid),
        .wk_tag   (wk_tag),
        .ents_o   (q_woke)
    );

    iq_wakeup #(.N(INS_W), .WK_W(WK_W)) u_wk_in (
        .ents_i   (in_raw),
        .wk_valid (wk_valid),
        .wk_tag   (wk_tag),
        .ents_o   (in_woke)
    );

    iq_select #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) u_sel (
        .ents     (q_ents),
        .kill     (kill),
        .fu_avail (fu_avail),
        .grant    (grant),
        .slot_vld (slot_vld),
        .slot_idx (slot_idx)
    );

    iq_compact #(.DEPTH(DEPTH), .INS_W(INS_W)) u_cmp (
        .ents     (q_woke),
        .keep     (keep),
        .new_ents (in_woke),
        .new_vld  (ins_valid),
        .ins_en   (ins_en),
        .nxt      (n_ents),
        .nxt_cnt  (n_cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_ents <= '0;
            q_cnt  <= '0;
        end else begin
            q_ents <= n_ents;
            q_cnt  <= n_cnt;
        end
    end

    for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
        assign iss_valid[s] = slot_vld[s];
        assign iss_dst[s]   = slot_vld[s] ? q_ents[slot_idx[s]].dst : '0;
        assign iss_cls[s]   = slot_vld[s] ? q_ents[slot_idx[s]].cls : '0;
        assign iss_seq[s]   = slot_vld[s] ? q_ents[slot_idx[s]].seq : '0;
    end

endmodule

// File: rtl/iq_collapse_chk.sv
module iq_collapse_chk #(
    parameter int DEPTH   = 20,
    parameter int ISSUE_W = 4,
    parameter int INS_W   = 4,
    parameter int CNT_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CNT_W-1:0]   q_cnt,
    input logic [ISSUE_W-1:0] iss_valid,
    input logic [INS_W-1:0]   ins_valid,
    input logic               ins_stall,
    input logic               sq_valid
);

    // R8: occupancy never exceeds capacity.
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_cnt) <= DEPTH);

    // R8: a refused request never grows the queue.
    a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_stall && (ins_valid != '0)) |=> (q_cnt <= $past(q_cnt)));

    // R2: issue slots are packed from slot 0 and bounded by occupancy.
    a_r2_slots_packed: assert property (@(posedge clk) disable iff (!rst_n)
        ((iss_valid & (iss_valid + 1'b1)) == '0) &&
        ($countones(iss_valid) <= int'(q_cnt)));

    // R1: an empty queue issues nothing.
    a_r1_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (q_cnt == '0) |-> (iss_valid == '0));

    // R5: without insertion or squash, occupancy drops by exactly the grants.
    a_r5_issue_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (!sq_valid && (ins_stall || (ins_valid == '0))) |=>
        (int'(q_cnt) == int'($past(q_cnt)) - $countones($past(iss_valid))));

    // R6: a squash never grows the queue.
    a_r6_squash_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |=> (q_cnt <= $past(q_cnt)));

endmodule

bind iq_collapse_top iq_collapse_chk #(
    .DEPTH   (DEPTH),
    .ISSUE_W (ISSUE_W),
    .INS_W   (INS_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_cnt     (q_cnt),
    .iss_valid (iss_valid),
    .ins_valid (ins_valid),
    .ins_stall (ins_stall),
    .sq_valid  (sq_valid)
);

// File: tb/test_iq_collapse_top.sv
module test_iq_collapse_top;

    localparam int DEPTH = 20;
    localparam int ISW   = 4;
    localparam int INW   = 4;
    localparam int WKW   = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [INW-1:0]        ins_valid;
    logic [INW-1:0][6:0]   ins_src1;
    logic [INW-1:0]        ins_src1_rdy;
    logic [INW-1:0][6:0]   ins_src2;
    logic [INW-1:0]        ins_src2_rdy;
    logic [INW-1:0][6:0]   ins_dst;
    logic [INW-1:0][1:0]   ins_cls;
    logic [INW-1:0][6:0]   ins_seq;
    logic                  ins_stall;
    logic [WKW-1:0]        wk_valid;
    logic [WKW-1:0][6:0]   wk_tag;
    logic [3:0]            fu_avail;
    logic                  sq_valid;
    logic [6:0]            sq_seq;
    logic [ISW-1:0]        iss_valid;
    logic [ISW-1:0][6:0]   iss_dst;
    logic [ISW-1:0][1:0]   iss_cls;
    logic [ISW-1:0][6:0]   iss_seq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    iq_collapse_top #(.DEPTH(DEPTH), .ISSUE_W(ISW), .INS_W(INW), .WK_W(WKW)) i_iq_collapse_top (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_src1(ins_src1), .ins_src1_rdy(ins_src1_rdy),
        .ins_src2(ins_src2), .ins_src2_rdy(ins_src2_rdy), .ins_dst(ins_dst),
        .ins_cls(ins_cls), .ins_seq(ins_seq), .ins_stall(ins_stall),
        .wk_valid(wk_valid), .wk_tag(wk_tag), .fu_avail(fu_avail),
        .sq_valid(sq_valid), .sq_seq(sq_seq),
        .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_cls(iss_cls), .iss_seq(iss_seq)
    );

    task automatic check(string rq, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic clr();
        ins_valid = '0; ins_src1 = '0; ins_src1_rdy = '0; ins_src2 = '0;
        ins_src2_rdy = '0; ins_dst = '0; ins_cls = '0; ins_seq = '0;
        wk_valid = '0; wk_tag = '0; sq_valid = 1'b0; sq_seq = '0;
    endtask

    // Clock edge, then clear one-shot inputs and settle.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        clr();
        #1;
    endtask

    task automatic put(int k, int seq, int s1, bit r1, int s2, bit r2, int cls);
        ins_valid[k] = 1'b1;
        ins_src1[k] = 7'(s1); ins_src1_rdy[k] = r1;
        ins_src2[k] = 7'(s2); ins_src2_rdy[k] = r2;
        ins_dst[k] = 7'(seq + 1); ins_cls[k] = 2'(cls); ins_seq[k] = 7'(seq);
    endtask

    task automatic drain();
        fu_avail = 4'hF;
        repeat (6) tick();
    endtask

    task automatic t_reset();
        fu_avail = 4'hF;
        #1;
        check("R1 iss_valid", int'(iss_valid), 0);
        check("R1 ins_stall", int'(ins_stall), 0);
    endtask

    task automatic t_basic();
        fu_avail = 4'hF;
        put(0, 0, 1, 1, 2, 1, 0); put(1, 1, 1, 1, 2, 1, 0); put(2, 2, 1, 1, 2, 1, 0);
        tick();
        check("R2 three ready", int'(iss_valid), 'b0111);
        check("R2 slot0 oldest", int'(iss_seq[0]), 0);
        check("R7 slot2 lane order", int'(iss_seq[2]), 2);
        check("R2 dst", int'(iss_dst[1]), 2);
        tick();
        check("R5 issued removed", int'(iss_valid), 0);
    endtask

    task automatic t_width();
        fu_avail = 4'h0;
        for (int k = 0; k < 4; k++) put(k, 10 + k, 1, 1, 1, 1, 0);
        tick();
        put(0, 14, 1, 1, 1, 1, 0); put(1, 15, 1, 1, 1, 1, 0);
        tick();
        fu_avail = 4'hF; #1;
        check("R2 four of six", int'(iss_valid), 'b1111);
        check("R2 first wave slot3", int'(iss_seq[3]), 13);
        tick();
        check("R5 second wave", int'(iss_valid), 'b0011);
        check("R5 second wave slot0", int'(iss_seq[0]), 14);
        drain();
    endtask

    task automatic t_wakeup();
        fu_avail = 4'hF;
        put(0, 20, 5, 0, 3, 1, 0); put(1, 21, 3, 1, 3, 1, 0);
        tick();
        check("R2 skip not ready", int'(iss_valid), 'b0001);
        check("R2 younger ready", int'(iss_seq[0]), 21);
        wk_valid[2] = 1'b1; wk_tag[2] = 7'd5; #1;
        check("R3 same cycle no issue", int'(iss_valid), 'b0001);
        tick();
        check("R3 woken issues", int'(iss_valid), 'b0001);
        check("R3 woken seq", int'(iss_seq[0]), 20);
        drain();
    endtask

    task automatic t_ins_wake();
        fu_avail = 4'hF;
        put(0, 30, 3, 1, 9, 0, 0);
        wk_valid[0] = 1'b1; wk_tag[0] = 7'd9;
        tick();
        check("R4 insert wake", int'(iss_valid), 'b0001);
        check("R4 insert wake seq", int'(iss_seq[0]), 30);
        drain();
    endtask

    task automatic t_class();
        fu_avail = 4'b0001;
        put(0, 40, 3, 1, 3, 1, 1); put(1, 41, 3, 1, 3, 1, 0);
        tick();
        check("R9 class blocked", int'(iss_valid), 'b0001);
        check("R9 class seq", int'(iss_seq[0]), 41);
        fu_avail = 4'hF; #1;
        check("R9 class freed", int'(iss_valid), 'b0011);
        check("R9 class freed cls", int'(iss_cls[0]), 1);
        drain();
    endtask

    task automatic t_squash();
        fu_avail = 4'h0;
        for (int k = 0; k < 4; k++) put(k, 50 + k, 3, 1, 3, 1, 0);
        tick();
        fu_avail = 4'hF; sq_valid = 1'b1; sq_seq = 7'd51; #1;
        check("R6 killed not granted", int'(iss_valid), 'b0011);
        check("R6 keep faulting", int'(iss_seq[1]), 51);
        check("R8 stall on squash", int'(ins_stall), 1);
        tick();
        check("R6 killed gone", int'(iss_valid), 0);
        drain();
    endtask

    task automatic t_wrap();
        fu_avail = 4'h0;
        put(0, 126, 3, 1, 3, 1, 0); put(1, 127, 3, 1, 3, 1, 0);
        put(2, 0, 3, 1, 3, 1, 0);   put(3, 1, 3, 1, 3, 1, 0);
        tick();
        sq_valid = 1'b1; sq_seq = 7'd127;
        tick();
        fu_avail = 4'hF; #1;
        check("R6 wrap survivors", int'(iss_valid), 'b0011);
        check("R6 wrap oldest", int'(iss_seq[0]), 126);
        drain();
    endtask

    task automatic t_full();
        fu_avail = 4'h0;
        for (int b = 0; b < 4; b++) begin
            for (int k = 0; k < 4; k++) put(k, 70 + 4 * b + k, 3, 1, 3, 1, 0);
            tick();
        end
        put(0, 86, 3, 1, 3, 1, 0); put(1, 87, 3, 1, 3, 1, 0);
        tick();
        for (int k = 0; k < 4; k++) put(k, 100 + k, 3, 1, 3, 1, 0);
        #1;
        check("R8 partial free stall", int'(ins_stall), 1);
        tick();
        put(0, 88, 3, 1, 3, 1, 0); put(1, 89, 3, 1, 3, 1, 0); #1;
        check("R8 exact fit", int'(ins_stall), 0);
        tick();
        put(0, 110, 3, 1, 3, 1, 0); #1;
        check("R8 full stall", int'(ins_stall), 1);
        tick();
        fu_avail = 4'hF; #1;
        for (int w = 0; w < 5; w++) begin
            check("R8 drain wave", int'(iss_valid), 'b1111);
            check("R8 drain order", int'(iss_seq[0]), 70 + 4 * w);
            tick();
        end
        check("R8 rejected absent", int'(iss_valid), 0);
    endtask

    task automatic t_compact();
        fu_avail = 4'h0;
        put(0, 60, 3, 1, 3, 1, 0); put(1, 61, 11, 0, 3, 1, 0);
        put(2, 62, 3, 1, 3, 1, 0); put(3, 63, 3, 1, 3, 1, 0);
        tick();
        fu_avail = 4'hF; #1;
        check("R2 skip hole", int'(iss_valid), 'b0111);
        check("R2 skip hole slot1", int'(iss_seq[1]), 62);
        tick();
        check("R5 stuck entry", int'(iss_valid), 0);
        put(0, 64, 3, 1, 3, 1, 0);
        wk_valid[3] = 1'b1; wk_tag[3] = 7'd11;
        tick();
        check("R5 compacted order", int'(iss_valid), 'b0011);
        check("R7 appended after survivor", int'(iss_seq[0]), 61);
        check("R7 appended seq", int'(iss_seq[1]), 64);
        drain();
    endtask

    initial begin
        clr();
        fu_avail = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_width();
        t_wakeup();
        t_ins_wake();
        t_class();
        t_squash();
        t_wrap();
        t_full();
        t_compact();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule